// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, for every received frame, whether it is kept or thrown away, based only on the 48-bit destination address and the frame length that an upstream header parser delivers in a single cycle. Several checks are applied in a fixed order. The length checks come first. After them come promiscuous mode, broadcast, a 64-bin multicast hash, and an exact match against the programmed station address. The order of the address checks matters because a broadcast address also has the group bit set. One cycle after the header is presented, the block reports the verdict, a reason code and a 3-bit delivery channel.

Software programs the filter through a small register window. This window holds a control word, a set/clear pair for the unicast channel mask, the length limit, the station address split over three words, and the two hash words. Four saturating event counters are kept: frames accepted, broadcasts accepted, multicasts accepted and frames dropped. Any write to one of the counters clears it.

Top module: `eth_rx_dest_filter`

## Requirements
- R1: Each cycle with `hdr_valid` high produces exactly one cycle of `dec_valid` on the following cycle, and `dec_valid` is never high otherwise. A dropped frame reports channel 0.
- R2: A frame whose length is greater than the length limit (register 3, reset value 1518) is dropped with reason 5, whatever its address. A length equal to the limit passes this check.
- R3: A frame shorter than 64 bytes is dropped with reason 6, unless control bit 23 (short frames allowed) is set. The long check is applied before the short check.
- R4: If control bit 21 is set, every frame that passes the length checks is accepted with reason 1, on the channel held in control bits 18:16.
- R5: A destination of all ones is broadcast. It is accepted with reason 2 on channel control[10:8] when control bit 13 is set, and dropped with reason 0 when that bit is clear.
- R6: A destination with bit 0 of its first byte set (`hdr_dest[40]`, the first byte being `hdr_dest[47:40]`) that is not broadcast is multicast. Its hash index is the XOR of the eight 6-bit slices `hdr_dest[47:42]`, `hdr_dest[41:36]`, and so on down to `hdr_dest[5:0]`. Index 0 to 31 selects that bit of register 7, and index 32 to 63 selects bit index-32 of register 8. The frame is accepted with reason 3 on channel control[2:0] when control bit 5 is set and the selected bit is 1. Otherwise it is dropped with reason 0.
- R7: Any other destination is accepted with reason 4 only if it equals the station address and the unicast mask is not zero. The channel is the lowest set bit of the mask. Otherwise the frame is dropped with reason 0. The station address is built from register 6 (first address byte in bits 7:0, fourth byte in bits 31:24), register 5 bits 7:0 (fifth byte) and register 4 bits 7:0 (sixth byte). Writing register 1 ORs `cfg_wdata[7:0]` into the mask. Writing register 2 clears the mask bits where `cfg_wdata[7:0]` is one.
- R8: Counters at registers 9 (accepted), 10 (broadcast accepted), 11 (multicast accepted) and 12 (dropped) are updated in the same cycle that `dec_valid` rises. They stop at all ones.
- R9: A write to a counter register sets that counter to zero. This clear wins over an increment in the same cycle.
- R10: After reset, the control word, mask, station address, hash words and counters read 0, the length limit reads 1518, and `dec_valid` is low.
- R11: `cfg_rdata` returns the addressed register in the same cycle. Control reads back only its defined bits (mask 0x00A72727). Registers 1 and 2 both read back the mask. Unused addresses read 0. A configuration write takes effect on the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index for both read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the addressed register |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_dest | input | 48 | Destination address, first byte in bits 47:40 |
| hdr_len | input | LEN_W | Frame length in bytes |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | 1 = keep the frame |
| dec_reason | output | 3 | 0 no match, 1 promiscuous, 2 broadcast, 3 multicast, 4 unicast, 5 too long, 6 too short |
| dec_chan | output | 3 | Delivery channel (0 when dropped) |

## Verification
The bound checker checks on every cycle that verdicts follow headers one for one, that an accepted verdict always carries an accept reason, and that an over-length frame can never be accepted. It also checks that counters move by at most one step, hold at all ones and return to zero after reset. Some behaviour only the bench scenarios can show. This includes the exact hash bin hit by a given address, the byte order of the station address, the choice of the lowest enabled channel, and the order in which the address classes are tried. It also includes the exact value of a counter after a run of frames and a clear that coincides with an increment.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int N_CH     = 8;
    localparam int CH_W     = $clog2(N_CH);
    localparam int MIN_LEN  = 64;
    localparam int N_CNT    = 4;

    localparam int CI_ACC   = 0;
    localparam int CI_BC    = 1;
    localparam int CI_MC    = 2;
    localparam int CI_DROP  = 3;

    localparam logic [31:0] CTRL_MASK = 32'h00A7_2727;

    typedef enum logic [3:0] {
        RA_CTRL     = 4'd0,
        RA_UC_SET   = 4'd1,
        RA_UC_CLR   = 4'd2,
        RA_MAXLEN   = 4'd3,
        RA_STA_LO   = 4'd4,
        RA_STA_MID  = 4'd5,
        RA_STA_HI   = 4'd6,
        RA_HASH_LO  = 4'd7,
        RA_HASH_HI  = 4'd8,
        RA_CNT_ACC  = 4'd9,
        RA_CNT_BC   = 4'd10,
        RA_CNT_MC   = 4'd11,
        RA_CNT_DROP = 4'd12
    } reg_addr_e;

    typedef enum logic [2:0] {
        RSN_NOMATCH = 3'd0,
        RSN_PROMISC = 3'd1,
        RSN_BCAST   = 3'd2,
        RSN_MCAST   = 3'd3,
        RSN_UCAST   = 3'd4,
        RSN_LONG    = 3'd5,
        RSN_SHORT   = 3'd6
    } reason_e;

    typedef struct packed {
        logic            short_ok;
        logic            prom_en;
        logic [CH_W-1:0] prom_ch;
        logic            bc_en;
        logic [CH_W-1:0] bc_ch;
        logic            mc_en;
        logic [CH_W-1:0] mc_ch;
    } ctrl_t;

    typedef struct packed {
        logic            accept;
        reason_e         reason;
        logic [CH_W-1:0] chan;
    } verdict_t;

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.short_ok = w[23];
        c.prom_en  = w[21];
        c.prom_ch  = w[18:16];
        c.bc_en    = w[13];
        c.bc_ch    = w[10:8];
        c.mc_en    = w[5];
        c.mc_ch    = w[2:0];
        return c;
    endfunction

    function automatic logic [5:0] fold_hash(input logic [47:0] a);
        logic [5:0] h;
        h = '0;
        for (int k = 0; k < 8; k++) h ^= a[47 - 6*k -: 6];
        return h;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MAXLEN_RST = 1518
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      ctrl_word,
    output logic [N_CH-1:0]  uc_mask,
    output logic [LEN_W-1:0] max_len,
    output logic [7:0]       sta_lo,
    output logic [7:0]       sta_mid,
    output logic [31:0]      sta_hi,
    output logic [63:0]      hash_tbl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_word <= '0;
            uc_mask   <= '0;
            max_len   <= LEN_W'(MAXLEN_RST);
            sta_lo    <= '0;
            sta_mid   <= '0;
            sta_hi    <= '0;
            hash_tbl  <= '0;
        end else if (we) begin
            case (addr)
                RA_CTRL:    ctrl_word      <= wdata & CTRL_MASK;
                RA_UC_SET:  uc_mask        <= uc_mask | wdata[N_CH-1:0];
                RA_UC_CLR:  uc_mask        <= uc_mask & ~wdata[N_CH-1:0];
                RA_MAXLEN:  max_len        <= wdata[LEN_W-1:0];
                RA_STA_LO:  sta_lo         <= wdata[7:0];
                RA_STA_MID: sta_mid        <= wdata[7:0];
                RA_STA_HI:  sta_hi         <= wdata;
                RA_HASH_LO: hash_tbl[31:0] <= wdata;
                RA_HASH_HI: hash_tbl[63:32] <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [47:0]      dest,
    input  logic [LEN_W-1:0] len,
    input  ctrl_t            ctrl,
    input  logic [N_CH-1:0]  uc_mask,
    input  logic [LEN_W-1:0] max_len,
    input  logic [47:0]      sta_addr,
    input  logic [63:0]      hash_tbl,
    output verdict_t         verdict,
    output logic             bc_hit,
    output logic             mc_hit
);

    logic            is_bc, is_mc, sta_hit, hash_bit;
    logic            too_long, too_short;
    logic [5:0]      hidx;
    logic [CH_W-1:0] uc_ch;

    assign is_bc     = &dest;
    assign is_mc     = dest[40] && !is_bc;
    assign sta_hit   = (dest == sta_addr);
    assign hidx      = fold_hash(dest);
    assign hash_bit  = hash_tbl[hidx];
    assign too_long  = len > max_len;
    assign too_short = (len < LEN_W'(MIN_LEN)) && !ctrl.short_ok;

    always_comb begin
        uc_ch = '0;
        for (int i = N_CH - 1; i >= 0; i--)
            if (uc_mask[i]) uc_ch = CH_W'(i);
    end

    always_comb begin
        verdict = '{accept: 1'b0, reason: RSN_NOMATCH, chan: '0};
        bc_hit  = 1'b0;
        mc_hit  = 1'b0;
        if (too_long) begin
            verdict.reason = RSN_LONG;
        end else if (too_short) begin
            verdict.reason = RSN_SHORT;
        end else if (ctrl.prom_en) begin
            verdict = '{accept: 1'b1, reason: RSN_PROMISC, chan: ctrl.prom_ch};
        end else if (is_bc) begin
            if (ctrl.bc_en) begin
                verdict = '{accept: 1'b1, reason: RSN_BCAST, chan: ctrl.bc_ch};
                bc_hit  = 1'b1;
            end
        end else if (is_mc) begin
            if (ctrl.mc_en && hash_bit) begin
                verdict = '{accept: 1'b1, reason: RSN_MCAST, chan: ctrl.mc_ch};
                mc_hit  = 1'b1;
            end
        end else if (sta_hit && (|uc_mask)) begin
            verdict = '{accept: 1'b1, reason: RSN_UCAST, chan: uc_ch};
        end
    end

endmodule

// File: rtl/rxf_counters.sv
module rxf_counters
    import rxf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_CNT-1:0]            inc,
    input  logic [N_CNT-1:0]            clr,
    output logic [N_CNT-1:0][CNT_W-1:0] cnt
);

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr[g])
                cnt[g] <= '0;
            else if (inc[g] && !(&cnt[g]))
                cnt[g] <= cnt[g] + 1'b1;
        end
    end

endmodule

// File: rtl/eth_rx_dest_filter.sv
module eth_rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 16,
    parameter int MAXLEN_RST = 1518
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             hdr_valid,
    input  logic [47:0]      hdr_dest,
    input  logic [LEN_W-1:0] hdr_len,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [2:0]       dec_reason,
    output logic [2:0]       dec_chan
);

    logic [31:0]                 ctrl_word;
    logic [N_CH-1:0]             uc_mask;
    logic [LEN_W-1:0]            max_len;
    logic [7:0]                  sta_lo, sta_mid;
    logic [31:0]                 sta_hi;
    logic [63:0]                 hash_tbl;
    logic [47:0]                 sta_addr;
    verdict_t                    verdict;
    logic                        bc_hit, mc_hit;
    logic [N_CNT-1:0]            inc, clr;
    logic [N_CNT-1:0][CNT_W-1:0] cnt;

    rxf_cfg_regs #(.LEN_W(LEN_W), .MAXLEN_RST(MAXLEN_RST)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl_word(ctrl_word), .uc_mask(uc_mask), .max_len(max_len),
        .sta_lo(sta_lo), .sta_mid(sta_mid), .sta_hi(sta_hi), .hash_tbl(hash_tbl)
    );

    // first received byte sits in the lowest byte of the high word
    assign sta_addr = {sta_hi[7:0], sta_hi[15:8], sta_hi[23:16], sta_hi[31:24],
                       sta_mid, sta_lo};

    rxf_decide #(.LEN_W(LEN_W)) u_dec (
        .dest(hdr_dest), .len(hdr_len), .ctrl(unpack_ctrl(ctrl_word)),
        .uc_mask(uc_mask), .max_len(max_len), .sta_addr(sta_addr),
        .hash_tbl(hash_tbl), .verdict(verdict), .bc_hit(bc_hit), .mc_hit(mc_hit)
    );

    always_comb begin
        inc          = '0;
        inc[CI_ACC]  = hdr_valid && verdict.accept;
        inc[CI_BC]   = hdr_valid && bc_hit;
        inc[CI_MC]   = hdr_valid && mc_hit;
        inc[CI_DROP] = hdr_valid && !verdict.accept;
        clr          = '0;
        clr[CI_ACC]  = cfg_we && (cfg_addr == RA_CNT_ACC);
        clr[CI_BC]   = cfg_we && (cfg_addr == RA_CNT_BC);
        clr[CI_MC]   = cfg_we && (cfg_addr == RA_CNT_MC);
        clr[CI_DROP] = cfg_we && (cfg_addr == RA_CNT_DROP);
    end

    rxf_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(inc), .clr(clr), .cnt(cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_reason <= RSN_NOMATCH;
            dec_chan   <= '0;
        end else begin
            dec_valid <= hdr_valid;
            if (hdr_valid) begin
                dec_accept <= verdict.accept;
                dec_reason <= verdict.reason;
                dec_chan   <= verdict.chan;
            end
        end
    end

    always_comb begin
        case (cfg_addr)
            RA_CTRL:     cfg_rdata = ctrl_word;
            RA_UC_SET,
            RA_UC_CLR:   cfg_rdata = 32'(uc_mask);
            RA_MAXLEN:   cfg_rdata = 32'(max_len);
            RA_STA_LO:   cfg_rdata = 32'(sta_lo);
            RA_STA_MID:  cfg_rdata = 32'(sta_mid);
            RA_STA_HI:   cfg_rdata = sta_hi;
            RA_HASH_LO:  cfg_rdata = hash_tbl[31:0];
            RA_HASH_HI:  cfg_rdata = hash_tbl[63:32];
            RA_CNT_ACC:  cfg_rdata = 32'(cnt[CI_ACC]);
            RA_CNT_BC:   cfg_rdata = 32'(cnt[CI_BC]);
            RA_CNT_MC:   cfg_rdata = 32'(cnt[CI_MC]);
            RA_CNT_DROP: cfg_rdata = 32'(cnt[CI_DROP]);
            default:     cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        hdr_valid,
    input logic [LEN_W-1:0]            hdr_len,
    input logic [LEN_W-1:0]            max_len,
    input logic                        dec_valid,
    input logic                        dec_accept,
    input logic [2:0]                  dec_reason,
    input logic [N_CNT-1:0][CNT_W-1:0] cnt
);

    assert_verdict_follows_R1: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> dec_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> !dec_valid);

    assert_long_dropped_R2: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && (hdr_len > max_len)) |=>
            (!dec_accept && dec_reason == RSN_LONG));

    assert_accept_reason_R4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_accept) |->
            (dec_reason inside {RSN_PROMISC, RSN_BCAST, RSN_MCAST, RSN_UCAST}));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!dec_valid && cnt == '0));

    for (genvar g = 0; g < N_CNT; g++) begin : g_chk
        assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
            (&cnt[g]) |=> ((&cnt[g]) || cnt[g] == '0));

        assert_single_step_R9: assert property (@(posedge clk) disable iff (rst)
            !(&cnt[g]) |=> (cnt[g] == $past(cnt[g]) + 1'b1 ||
                            cnt[g] == $past(cnt[g]) || cnt[g] == '0));
    end

endmodule

bind eth_rx_dest_filter rxf_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_len(hdr_len),
    .max_len(max_len), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_reason(dec_reason), .cnt(cnt)
);

// File: tb/sim_eth_rx_dest_filter.sv
`timescale 1ns/1ps
module sim_eth_rx_dest_filter;

    localparam int LEN_W = 16;
    localparam int CNT_W = 8;
    localparam logic [31:0] CMASK = 32'h00A7_2727;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             hdr_valid = 1'b0;
    logic [47:0]      hdr_dest = '0;
    logic [LEN_W-1:0] hdr_len = '0;
    logic             dec_valid, dec_accept;
    logic [2:0]       dec_reason, dec_chan;

    always #2 clk = ~clk;

    eth_rx_dest_filter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hdr_valid(hdr_valid),
        .hdr_dest(hdr_dest), .hdr_len(hdr_len), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_reason(dec_reason), .dec_chan(dec_chan)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // shadow configuration and counters
    logic [31:0] m_ctrl = 0;
    logic [7:0]  m_mask = 0;
    logic [15:0] m_max = 16'd1518;
    logic [7:0]  m_lo = 0, m_mid = 0;
    logic [31:0] m_hi = 0;
    logic [63:0] m_hash = 0;
    int          m_cnt [4] = '{0, 0, 0, 0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [7:0] b [6];
        logic [7:0] acc;
        for (int i = 0; i < 6; i++) b[i] = a[47 - 8*i -: 8];
        acc = 0;
        for (int j = 0; j < 6; j += 3) begin
            acc ^= (b[j] >> 2) ^ (b[j] << 4);
            acc ^= (b[j+1] >> 4) ^ (b[j+1] << 2);
            acc ^= (b[j+2] >> 6) ^ b[j+2];
        end
        return acc[5:0];
    endfunction

    // expected {accept, reason, chan, bcast_acc, mcast_acc}
    function automatic logic [8:0] ref_verdict(input logic [47:0] d, input int len);
        logic [47:0] sta;
        int lowest;
        sta = {m_hi[7:0], m_hi[15:8], m_hi[23:16], m_hi[31:24], m_mid, m_lo};
        lowest = 0;
        for (int i = 7; i >= 0; i--) if (m_mask[i]) lowest = i;
        if (len > m_max)                   return {1'b0, 3'd5, 3'd0, 2'b00};
        if (len < 64 && !m_ctrl[23])       return {1'b0, 3'd6, 3'd0, 2'b00};
        if (m_ctrl[21])                    return {1'b1, 3'd1, m_ctrl[18:16], 2'b00};
        if (d == '1)
            return m_ctrl[13] ? {1'b1, 3'd2, m_ctrl[10:8], 2'b10} : 9'd0;
        if (d[40])
            return (m_ctrl[5] && m_hash[ref_hash(d)]) ? {1'b1, 3'd3, m_ctrl[2:0], 2'b01} : 9'd0;
        if (d == sta && m_mask != 0)       return {1'b1, 3'd4, 3'(lowest), 2'b00};
        return 9'd0;
    endfunction

    function automatic int sat_inc(input int v);
        return (v >= int'(CMAX)) ? v : v + 1;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            4'd0: m_ctrl = d & CMASK;
            4'd1: m_mask = m_mask | d[7:0];
            4'd2: m_mask = m_mask & ~d[7:0];
            4'd3: m_max = d[15:0];
            4'd4: m_lo = d[7:0];
            4'd5: m_mid = d[7:0];
            4'd6: m_hi = d;
            4'd7: m_hash[31:0] = d;
            4'd8: m_hash[63:32] = d;
            4'd9, 4'd10, 4'd11, 4'd12: m_cnt[a - 9] = 0;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic send(input string req, input logic [47:0] d, input int len);
        logic [8:0] e;
        @(negedge clk);
        e = ref_verdict(d, len);
        hdr_valid = 1'b1; hdr_dest = d; hdr_len = LEN_W'(len);
        if (e[8]) m_cnt[0] = sat_inc(m_cnt[0]); else m_cnt[3] = sat_inc(m_cnt[3]);
        if (e[1]) m_cnt[1] = sat_inc(m_cnt[1]);
        if (e[0]) m_cnt[2] = sat_inc(m_cnt[2]);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk({req, " valid"}, dec_valid, 1'b1);
        chk({req, " verdict"}, {dec_accept, dec_reason, dec_chan}, e[8:2]);
    endtask

    task automatic cnt_chk(input string req);
        for (int i = 0; i < 4; i++) rd_chk(req, 4'(9 + i), 32'(m_cnt[i]));
    endtask

    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MC  = 48'h01_00_5E_00_00_01;

    initial begin
        logic [5:0] hi;
        void'($urandom(32'h1F2E_3D4C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 dec_valid after reset", dec_valid, 1'b0);
        rd_chk("R10 max length reset", 4'd3, 32'd1518);
        rd_chk("R10 control reset", 4'd0, 32'd0);
        rd_chk("R10 mask reset", 4'd1, 32'd0);
        rd_chk("R10 hash reset", 4'd8, 32'd0);
        cnt_chk("R10 counters reset");

        // R7 station address and unicast mask
        send("R7 empty mask drop", STA, 100);
        wr(4'd6, 32'h33_22_11_02); wr(4'd5, 32'h44); wr(4'd4, 32'h55);
        rd_chk("R11 station high readback", 4'd6, 32'h33221102);
        send("R7 match but empty mask", STA, 100);
        wr(4'd1, 32'h0C);
        send("R7 unicast lowest channel 2", STA, 100);
        wr(4'd2, 32'h04);
        rd_chk("R7 mask after clear", 4'd2, 32'h08);
        send("R7 unicast channel 3", STA, 100);
        send("R7 other unicast dropped", STA ^ 48'h1, 100);

        // R5 broadcast
        send("R5 broadcast disabled", BC, 100);
        wr(4'd0, 32'hFFFF_FFFF);
        rd_chk("R11 control defined bits", 4'd0, CMASK);
        wr(4'd0, 32'h0000_2500);
        send("R5 broadcast channel 5", BC, 100);

        // R6 multicast hash
        hi = ref_hash(MC);
        wr(4'd0, 32'h0000_0024);
        send("R6 empty hash drop", MC, 100);
        if (hi >= 32) wr(4'd8, 32'h1 << (hi - 32)); else wr(4'd7, 32'h1 << hi);
        send("R6 hash bin hit", MC, 100);
        send("R6 other bin miss", MC ^ 48'h40, 100);
        wr(4'd7, '1); wr(4'd8, '1);
        send("R6 all ones accepts any group", MC ^ 48'h0000_1234_5678, 100);
        send("R6 broadcast is not multicast", BC, 100);

        // R2 and R3 length limits
        send("R2 at limit accepted", STA, 1518);
        send("R2 over limit", STA, 1519);
        send("R3 63 bytes short", STA, 63);
        send("R3 64 bytes ok", STA, 64);
        wr(4'd0, 32'h0080_0024);
        send("R3 short allowed", STA, 20);
        wr(4'd3, 32'd100);
        send("R2 programmed limit", STA, 101);

        // R4 promiscuous
        wr(4'd0, 32'h0026_2524);
        send("R4 promiscuous foreign address", 48'h0A_0B_0C_0D_0E_0F, 80);
        send("R4 promiscuous still length checked", BC, 200);
        cnt_chk("R8 counters after directed");

        // R9 clear, also coinciding with an increment
        wr(4'd9, 0);
        rd_chk("R9 accepted counter cleared", 4'd9, 0);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_dest = STA; hdr_len = 16'd80;
        cfg_we = 1'b1; cfg_addr = 4'd9;
        @(negedge clk);
        hdr_valid = 1'b0; cfg_we = 1'b0;
        m_cnt[0] = 0;
        rd_chk("R9 clear wins over increment", 4'd9, 0);

        // R8 saturation on the drop counter
        wr(4'd0, 32'h0);
        for (int i = 0; i < 300; i++) send("R8 drop run", STA, 30);
        rd_chk("R8 drop counter saturated", 4'd12, 32'(CMAX));

        // random mix
        wr(4'd3, 32'd1518);
        for (int c = 0; c < 12; c++) begin
            wr(4'd0, $urandom);
            wr(4'd1, $urandom); wr(4'd2, $urandom);
            wr(4'd7, $urandom); wr(4'd8, $urandom);
            wr(4'd3, $urandom_range(800, 1600));
            for (int f = 0; f < 40; f++) begin
                logic [47:0] d;
                d = {$urandom, $urandom} ;
                case ($urandom_range(0, 3))
                    0: d = BC;
                    1: d = STA;
                    2: d[40] = 1'b1;
                    default: d[40] = 1'b0;
                endcase
                send("R1 R6 R7 random frame", d, $urandom_range(40, 1650));
            end
            cnt_chk("R8 counters random");
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule